// File: doc/BRIEF.md
# Programmable Text-Mode CRT Timing Controller

This block generates the raster timing for a character-cell display. The host programs every timing figure through a pair of ports: an index port chooses one of eighteen internal registers and a data port reads or writes it. From those registers the block counts character clocks, scan lines and character rows. It drives horizontal and vertical sync, display enable, the current row and scan line, a linear refresh address into a 4 KB character-plus-attribute buffer, and a cursor strobe.

The block also decodes the adapter's 16-address I/O window. A control port enables the high-resolution mode, video and blinking. Until the host sets high-resolution mode, every access outside the control port stalls through a ready output held low, so the first write must go to the control port. Reset loads the 80x25 monochrome timing, so enabling the mode and video is enough to get a working raster. Character generation, pixel shifting, the buffer RAM and the analog stage sit outside the block.

Top module: `txt_crtc`

## Requirements
- R1: After reset, the timing registers hold these values: index 0 = 0x61, 1 = 0x50, 2 = 0x52, 3 = 0x0F, 4 = 0x19, 5 = 0x06, 6 = 0x19, 7 = 0x19, 8 = 0x02, 9 = 0x0D, 10 = 0x0B, 11 = 0x0C, and 12 to 15 = 0. The control register is cleared, so disp_en_o is low.
- R2: While control bit 0 (high-resolution) is 0, a read or write at any offset other than 8 holds io_ready_o low, returns 0 and has no effect. Accesses at offset 8 always complete with io_ready_o high.
- R3: A write at offset 4 sets the 5-bit register index. Offset 5 reads or writes the indexed register for indices 0 to 15. For index 16, 17 or higher, writes are ignored and reads return 0.
- R4: In the control port at offset 8, bit 0 is high-resolution, bit 3 is video enable and bit 5 is blink enable. Other written bits are dropped, so reading back 0xFF written gives 0x29. When bit 3 is 0, disp_en_o and cursor_o stay low.
- R5: A read at offset 0xA returns bit 0 = 1 while the raster is outside the displayed area and bit 3 = vsync_o, with all other bits 0. Offsets 0 to 3, 6, 7, 9 and 0xB to 0xF read 0 and ignore writes.
- R6: A scan line lasts (index 0)+1 clocks. disp_en_o is high for the first (index 1) clocks of a line in a displayed row. hsync_o rises when the character count equals index 2 and stays high for (index 3 bits 3:0) clocks.
- R7: A character row has (index 9 bits 4:0)+1 scan lines. A frame has (index 4)+1 rows followed by (index 5 bits 4:0) extra scan lines. Only rows below index 6 are displayed.
- R8: vsync_o goes high at the first scan line of row (index 7) and stays high for 16 scan lines.
- R9: At the top of each frame, the refresh address row base reloads from the 14-bit start address {index 12 bits 5:0, index 13}. At each new row it grows by (index 1). It stays the same for every scan line of a row. ma_o = (row base + character count) mod 4096.
- R10: cursor_o is high when display is enabled, the 14-bit refresh address equals {index 14 bits 5:0, index 15}, and sl_o lies between index 10 bits 4:0 and index 11 bits 4:0 inclusive.
- R11: With blink enabled, a frame counter hides the cursor for 8 of every 16 frames, and blink_o is high during the hidden frames. With blink disabled, blink_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Character clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_addr_i | input | 4 | Offset within the I/O window |
| io_wr_i | input | 1 | Write strobe |
| io_rd_i | input | 1 | Read strobe |
| io_wdata_i | input | 8 | Write data |
| io_rdata_o | output | 8 | Read data, valid during io_rd_i |
| io_ready_o | output | 1 | Low while an access is stalled |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| disp_en_o | output | 1 | Display enable, gated by video enable |
| row_o | output | 7 | Current character row |
| sl_o | output | 5 | Current scan line in the row (adjust line count during the adjust lines) |
| ma_o | output | 12 | Refresh memory address |
| cursor_o | output | 1 | Cursor strobe |
| blink_o | output | 1 | High during blink-hidden frames |

## Verification
The hardest case to reach is the cursor falling in the right place under blink. The match depends on the 14-bit address, the scan-line window and a frame counter that advances only at frame ends. To reach it, the bench programs a tiny raster of 10 clocks by 26 lines with a start address near the top of the 4 KB range, so the refresh address wraps inside the first row. It then scans whole frames between vsync edges, rebuilding the expected address from row_o and the column count. With blink enabled, it counts how many of 16 consecutive frames show the cursor.

// File: rtl/crtc_pkg.sv
package crtc_pkg;
  localparam int unsigned NREGS  = 16;
  localparam int unsigned IDX_W  = 5;
  localparam int unsigned ADDR_W = 14;

  localparam logic [3:0] OFS_INDEX = 4'h4;
  localparam logic [3:0] OFS_DATA  = 4'h5;
  localparam logic [3:0] OFS_CTRL  = 4'h8;
  localparam logic [3:0] OFS_STAT  = 4'hA;

  localparam int unsigned CB_HIRES = 0;
  localparam int unsigned CB_VIDEO = 3;
  localparam int unsigned CB_BLINK = 5;
  localparam logic [7:0]  CTRL_MASK = 8'h29;

  typedef logic [NREGS-1:0][7:0] regfile_t;

  function automatic logic [7:0] rst_val(input int unsigned i);
    case (i)
      0:       return 8'h61;
      1:       return 8'h50;
      2:       return 8'h52;
      3:       return 8'h0F;
      4:       return 8'h19;
      5:       return 8'h06;
      6:       return 8'h19;
      7:       return 8'h19;
      8:       return 8'h02;
      9:       return 8'h0D;
      10:      return 8'h0B;
      11:      return 8'h0C;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/crtc_host.sv
module crtc_host
  import crtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] addr_i,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  output logic       ready_o,
  input  logic       de_raw_i,
  input  logic       vsync_i,
  output regfile_t   regs_o,
  output logic       video_en_o,
  output logic       blink_en_o
);
  logic [IDX_W-1:0] idx_q;
  regfile_t         regs_q;
  logic [7:0]       ctrl_q;
  logic             stall;
  logic             idx_ok;

  assign stall   = (wr_i | rd_i) && (addr_i != OFS_CTRL) && !ctrl_q[CB_HIRES];
  assign ready_o = !stall;
  assign idx_ok  = idx_q < IDX_W'(NREGS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      ctrl_q <= '0;
      for (int i = 0; i < NREGS; i++) regs_q[i] <= rst_val(i);
    end else if (wr_i && !stall) begin
      case (addr_i)
        OFS_INDEX: idx_q <= wdata_i[IDX_W-1:0];
        OFS_DATA:  if (idx_ok) regs_q[idx_q[3:0]] <= wdata_i;
        OFS_CTRL:  ctrl_q <= wdata_i & CTRL_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i && !stall) begin
      case (addr_i)
        OFS_INDEX: rdata_o = {{(8-IDX_W){1'b0}}, idx_q};
        OFS_DATA:  rdata_o = idx_ok ? regs_q[idx_q[3:0]] : 8'h00;
        OFS_CTRL:  rdata_o = ctrl_q;
        OFS_STAT:  rdata_o = {4'b0, vsync_i, 2'b0, !de_raw_i};
        default:   rdata_o = '0;
      endcase
    end
  end

  assign regs_o     = regs_q;
  assign video_en_o = ctrl_q[CB_VIDEO];
  assign blink_en_o = ctrl_q[CB_BLINK];

  p_stall_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i != OFS_CTRL && !ctrl_q[CB_HIRES]) |=> ($stable(regs_q) && $stable(idx_q)));

  p_reserved_ignored_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && ready_o && addr_i == OFS_DATA && idx_q >= IDX_W'(NREGS)) |=> $stable(regs_q));

  p_ctrl_bit_only_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_CTRL) |=> (ctrl_q == ($past(wdata_i) & CTRL_MASK)));
endmodule

// File: rtl/crtc_timing.sv
module crtc_timing #(
  parameter int unsigned H_W      = 8,
  parameter int unsigned ROW_W    = 7,
  parameter int unsigned SL_W     = 5,
  parameter int unsigned VS_LINES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [H_W-1:0]   htot_i,
  input  logic [H_W-1:0]   hdisp_i,
  input  logic [H_W-1:0]   hpos_i,
  input  logic [3:0]       hwid_i,
  input  logic [ROW_W-1:0] vtot_i,
  input  logic [ROW_W-1:0] vdisp_i,
  input  logic [ROW_W-1:0] vpos_i,
  input  logic [SL_W-1:0]  vadj_i,
  input  logic [SL_W-1:0]  maxsl_i,
  output logic [H_W-1:0]   h_cnt_o,
  output logic [ROW_W-1:0] row_o,
  output logic [SL_W-1:0]  sl_o,
  output logic             de_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             row_adv_o,
  output logic             frame_end_o
);
  localparam int unsigned VS_W = $clog2(VS_LINES + 1);

  logic [H_W-1:0]   h_q;
  logic [ROW_W-1:0] row_q;
  logic [SL_W-1:0]  sl_q;
  logic             in_adj_q;
  logic [VS_W-1:0]  vs_q;

  logic line_end, sl_last, row_last, adj_last, frame_end, row_adv, vs_start;

  assign line_end  = h_q >= htot_i;
  assign sl_last   = sl_q >= maxsl_i;
  assign row_last  = row_q >= vtot_i;
  assign adj_last  = ({1'b0, sl_q} + 1'b1) >= {1'b0, vadj_i};
  assign frame_end = line_end && (in_adj_q ? adj_last
                                           : (sl_last && row_last && vadj_i == '0));
  assign row_adv   = line_end && !in_adj_q && sl_last && !row_last;
  assign vs_start  = (row_adv && (row_q + 1'b1) == vpos_i) || (frame_end && vpos_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q      <= '0;
      row_q    <= '0;
      sl_q     <= '0;
      in_adj_q <= 1'b0;
      vs_q     <= '0;
    end else begin
      h_q <= line_end ? '0 : h_q + 1'b1;
      if (line_end) begin
        if (frame_end) begin
          row_q    <= '0;
          sl_q     <= '0;
          in_adj_q <= 1'b0;
        end else if (in_adj_q) begin
          sl_q <= sl_q + 1'b1;
        end else if (sl_last) begin
          sl_q <= '0;
          if (row_last) in_adj_q <= 1'b1;
          else          row_q    <= row_q + 1'b1;
        end else begin
          sl_q <= sl_q + 1'b1;
        end
        if (vs_start)         vs_q <= VS_W'(VS_LINES);
        else if (vs_q != '0)  vs_q <= vs_q - 1'b1;
      end
    end
  end

  assign h_cnt_o     = h_q;
  assign row_o       = row_q;
  assign sl_o        = sl_q;
  assign de_o        = (h_q < hdisp_i) && (row_q < vdisp_i) && !in_adj_q;
  assign hsync_o     = ({1'b0, h_q} >= {1'b0, hpos_i}) &&
                       ({1'b0, h_q} < ({1'b0, hpos_i} + (H_W+1)'(hwid_i)));
  assign vsync_o     = vs_q != '0;
  assign row_adv_o   = row_adv;
  assign frame_end_o = frame_end;

  p_line_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_end |=> (h_q == '0));

  p_frame_top_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> (row_q == '0 && sl_q == '0 && !in_adj_q));

  p_vsync_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(vsync_o) && $stable(vpos_i)) |-> (row_q == vpos_i && sl_q == '0 && !in_adj_q && h_q == '0));
endmodule

// File: rtl/crtc_refresh.sv
module crtc_refresh #(
  parameter int unsigned H_W        = 8,
  parameter int unsigned SL_W       = 5,
  parameter int unsigned ADDR_W     = 14,
  parameter int unsigned MA_W       = 12,
  parameter int unsigned BLINK_LOG2 = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [H_W-1:0]    h_cnt_i,
  input  logic [SL_W-1:0]   sl_i,
  input  logic              de_i,
  input  logic [H_W-1:0]    hdisp_i,
  input  logic              row_adv_i,
  input  logic              frame_end_i,
  input  logic [ADDR_W-1:0] start_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic [SL_W-1:0]   cs_i,
  input  logic [SL_W-1:0]   ce_i,
  input  logic              blink_en_i,
  output logic [MA_W-1:0]   ma_o,
  output logic              cursor_o,
  output logic              blink_o
);
  logic [ADDR_W-1:0]   base_q;
  logic [BLINK_LOG2:0] frame_q;
  logic [ADDR_W-1:0]   ma_full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      frame_q <= '0;
    end else begin
      if (frame_end_i) begin
        base_q  <= start_i;
        frame_q <= frame_q + 1'b1;
      end else if (row_adv_i) begin
        base_q  <= base_q + ADDR_W'(hdisp_i);
      end
    end
  end

  assign ma_full  = base_q + ADDR_W'(h_cnt_i);
  assign ma_o     = ma_full[MA_W-1:0];
  assign blink_o  = blink_en_i && frame_q[BLINK_LOG2];
  assign cursor_o = de_i && (ma_full == cur_i) && (sl_i >= cs_i) && (sl_i <= ce_i) && !blink_o;

  p_cursor_needs_de_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cursor_o |-> de_i);

  p_frame_base_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> (base_q == $past(start_i)));

  p_blink_hides_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blink_o |-> !cursor_o);
endmodule

// File: rtl/txt_crtc.sv
module txt_crtc
  import crtc_pkg::*;
#(
  parameter int unsigned MA_W       = 12,
  parameter int unsigned ROW_W      = 7,
  parameter int unsigned SL_W       = 5,
  parameter int unsigned VS_LINES   = 16,
  parameter int unsigned BLINK_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       io_addr_i,
  input  logic             io_wr_i,
  input  logic             io_rd_i,
  input  logic [7:0]       io_wdata_i,
  output logic [7:0]       io_rdata_o,
  output logic             io_ready_o,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             disp_en_o,
  output logic [ROW_W-1:0] row_o,
  output logic [SL_W-1:0]  sl_o,
  output logic [MA_W-1:0]  ma_o,
  output logic             cursor_o,
  output logic             blink_o
);
  localparam int unsigned H_W = 8;

  regfile_t          regs;
  logic              video_en, blink_en;
  logic              de_raw, de_gated, row_adv, frame_end;
  logic [H_W-1:0]    h_cnt;
  logic [ADDR_W-1:0] start_addr, cur_addr;
  logic              unused_bits;

  assign start_addr = {regs[12][5:0], regs[13]};
  assign cur_addr   = {regs[14][5:0], regs[15]};
  assign de_gated   = de_raw && video_en;
  assign disp_en_o  = de_gated;
  assign unused_bits = ^{regs[8], regs[3][7:4], regs[4][7:ROW_W], regs[6][7:ROW_W],
                         regs[7][7:ROW_W], regs[5][7:SL_W], regs[9][7:SL_W],
                         regs[10][7:SL_W], regs[11][7:SL_W], regs[12][7:6], regs[14][7:6]};

  crtc_host u_host (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (io_addr_i),
    .wr_i       (io_wr_i),
    .rd_i       (io_rd_i),
    .wdata_i    (io_wdata_i),
    .rdata_o    (io_rdata_o),
    .ready_o    (io_ready_o),
    .de_raw_i   (de_raw),
    .vsync_i    (vsync_o),
    .regs_o     (regs),
    .video_en_o (video_en),
    .blink_en_o (blink_en)
  );

  crtc_timing #(.H_W(H_W), .ROW_W(ROW_W), .SL_W(SL_W), .VS_LINES(VS_LINES)) u_timing (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .htot_i      (regs[0]),
    .hdisp_i     (regs[1]),
    .hpos_i      (regs[2]),
    .hwid_i      (regs[3][3:0]),
    .vtot_i      (regs[4][ROW_W-1:0]),
    .vdisp_i     (regs[6][ROW_W-1:0]),
    .vpos_i      (regs[7][ROW_W-1:0]),
    .vadj_i      (regs[5][SL_W-1:0]),
    .maxsl_i     (regs[9][SL_W-1:0]),
    .h_cnt_o     (h_cnt),
    .row_o       (row_o),
    .sl_o        (sl_o),
    .de_o        (de_raw),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .row_adv_o   (row_adv),
    .frame_end_o (frame_end)
  );

  crtc_refresh #(.H_W(H_W), .SL_W(SL_W), .ADDR_W(ADDR_W), .MA_W(MA_W),
                 .BLINK_LOG2(BLINK_LOG2)) u_refresh (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .h_cnt_i     (h_cnt),
    .sl_i        (sl_o),
    .de_i        (de_gated),
    .hdisp_i     (regs[1]),
    .row_adv_i   (row_adv),
    .frame_end_i (frame_end),
    .start_i     (start_addr),
    .cur_i       (cur_addr),
    .cs_i        (regs[10][SL_W-1:0]),
    .ce_i        (regs[11][SL_W-1:0]),
    .blink_en_i  (blink_en),
    .ma_o        (ma_o),
    .cursor_o    (cursor_o),
    .blink_o     (blink_o)
  );

  p_video_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !video_en |-> (!disp_en_o && !cursor_o));
endmodule

// File: tb/sim_txt_crtc.sv
module sim_txt_crtc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] io_addr = '0;
  logic       io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_wdata = '0;
  logic [7:0] io_rdata;
  logic       io_ready, hsync_o, vsync_o, disp_en_o, cursor_o, blink_o;
  logic [6:0] row_o;
  logic [4:0] sl_o;
  logic [11:0] ma_o;

  int total = 0, bad = 0;
  bit done = 0;

  int cfg_htot = 9, cfg_hdisp = 6, cfg_hpos = 7, cfg_hwid = 2;
  int cfg_start = 'h0FFC, cfg_cur = 'h1004, cfg_cs = 1, cfg_ce = 2;
  bit chk_cur = 1;
  int m_lines, m_de_lines, m_vs, m_hper_bad, m_hpos_bad, m_hsw_bad, m_dew_bad;
  int m_ma_bad, m_cur_bad, m_cur;

  always #2 clk = ~clk;

  txt_crtc u0 (
    .clk_i(clk), .rst_ni(rst_n), .io_addr_i(io_addr), .io_wr_i(io_wr), .io_rd_i(io_rd),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .io_ready_o(io_ready),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .disp_en_o(disp_en_o), .row_o(row_o),
    .sl_o(sl_o), .ma_o(ma_o), .cursor_o(cursor_o), .blink_o(blink_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [3:0] a, input logic [7:0] d, output bit rdy);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    #1 rdy = io_ready;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [3:0] a, output logic [7:0] d, output bit rdy);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    #1 d = io_rdata; rdy = io_ready;
    io_rd = 1'b0;
  endtask

  task automatic wr_reg(input int idx, input int val);
    bit r;
    io_write(4'h4, 8'(idx), r);
    io_write(4'h5, 8'(val), r);
  endtask

  task automatic rd_reg(input int idx, output logic [7:0] d);
    bit r;
    io_write(4'h4, 8'(idx), r);
    io_read(4'h5, d, r);
  endtask

  task automatic frame_scan();
    logic pv, ph, pd;
    int t = 0, lh = -1, lhs = 0, lds = -1, col = 0, full;
    bit ecur;
    m_lines = 0; m_de_lines = 0; m_vs = 0; m_hper_bad = 0; m_hpos_bad = 0;
    m_hsw_bad = 0; m_dew_bad = 0; m_ma_bad = 0; m_cur_bad = 0; m_cur = 0;
    @(negedge clk); pv = vsync_o;
    forever begin
      @(negedge clk);
      if (vsync_o && !pv) break;
      pv = vsync_o;
    end
    pv = 1'b1; ph = hsync_o; pd = disp_en_o;
    forever begin
      @(negedge clk); t++;
      if ((vsync_o && !pv) || t > 3000) break;
      pv = vsync_o;
      if (hsync_o && !ph) begin
        m_lines++;
        if (vsync_o) m_vs++;
        if (lh >= 0 && t - lh != cfg_htot + 1) m_hper_bad++;
        if (lds >= 0 && t - lds != cfg_hpos) m_hpos_bad++;
        lds = -1; lh = t; lhs = t;
      end
      if (!hsync_o && ph && t - lhs != cfg_hwid) m_hsw_bad++;
      if (!disp_en_o && pd && t - lds != cfg_hdisp) m_dew_bad++;
      if (disp_en_o && !pd) begin m_de_lines++; lds = t; col = 0; end
      else if (disp_en_o) col++;
      full = cfg_start + int'(row_o) * cfg_hdisp + col;
      if (disp_en_o && int'(ma_o) != (full & 'hFFF)) m_ma_bad++;
      ecur = disp_en_o && full == cfg_cur && int'(sl_o) >= cfg_cs && int'(sl_o) <= cfg_ce;
      if (cursor_o) m_cur++;
      if (chk_cur && cursor_o != ecur) m_cur_bad++;
      ph = hsync_o; pd = disp_en_o;
    end
  endtask

  task automatic t_reset_and_stall();
    bit r; logic [7:0] d;
    @(negedge clk);
    chk(disp_en_o == 1'b0, "R1 disp_en after reset", disp_en_o, 0);
    io_write(4'h4, 8'h03, r);
    chk(r == 1'b0, "R2 index write stalls", r, 0);
    io_read(4'h5, d, r);
    chk(r == 1'b0 && d == 8'h00, "R2 data read stalls", d, 0);
    io_write(4'h8, 8'h01, r);
    chk(r == 1'b1, "R2 control write completes", r, 1);
    io_read(4'h5, d, r);
    chk(r == 1'b1 && d == 8'h61, "R2 stalled index write had no effect", d, 'h61);
    rd_reg(4, d);  chk(d == 8'h19, "R1 vertical total", d, 'h19);
    rd_reg(5, d);  chk(d == 8'h06, "R1 adjust", d, 6);
    rd_reg(9, d);  chk(d == 8'h0D, "R1 max scan line", d, 'h0D);
    rd_reg(11, d); chk(d == 8'h0C, "R1 cursor end", d, 'h0C);
    rd_reg(8, d);  chk(d == 8'h02, "R1 interlace", d, 2);
  endtask

  task automatic t_program();
    logic [7:0] d;
    wr_reg(0, cfg_htot); wr_reg(1, cfg_hdisp); wr_reg(2, cfg_hpos); wr_reg(3, cfg_hwid);
    wr_reg(4, 7); wr_reg(5, 2); wr_reg(6, 5); wr_reg(7, 6); wr_reg(9, 2);
    wr_reg(10, cfg_cs); wr_reg(11, cfg_ce);
    wr_reg(12, 'h0F); wr_reg(13, 'hFC); wr_reg(14, 'h10); wr_reg(15, 'h04);
    rd_reg(2, d);  chk(d == 8'h07, "R3 readback", d, 7);
    rd_reg(15, d); chk(d == 8'h04, "R3 readback cursor low", d, 4);
    wr_reg(16, 'h55);
    rd_reg(16, d); chk(d == 8'h00, "R3 reserved 16 reads zero", d, 0);
    wr_reg(17, 'hAA);
    rd_reg(17, d); chk(d == 8'h00, "R3 reserved 17 reads zero", d, 0);
    rd_reg(0, d);  chk(d == 8'h09, "R3 reserved write left index 0", d, 9);
    rd_reg(1, d);  chk(d == 8'h06, "R3 reserved write left index 1", d, 6);
  endtask

  task automatic t_ctrl_status();
    bit r; logic [7:0] d; int mism = 0;
    io_write(4'h8, 8'hFF, r);
    io_read(4'h8, d, r);
    chk(d == 8'h29, "R4 control readback", d, 'h29);
    io_write(4'h8, 8'h09, r);
    io_write(4'h9, 8'hFF, r);
    io_write(4'h0, 8'hFF, r);
    io_read(4'h8, d, r);
    chk(d == 8'h09, "R5 reserved write ignored", d, 9);
    io_read(4'h9, d, r); chk(d == 8'h00, "R5 offset 9 reads zero", d, 0);
    io_read(4'hB, d, r); chk(d == 8'h00, "R5 offset B reads zero", d, 0);
    io_read(4'h0, d, r); chk(d == 8'h00, "R5 offset 0 reads zero", d, 0);
    for (int i = 0; i < 600; i++) begin
      io_read(4'hA, d, r);
      if (d != {4'b0, vsync_o, 2'b0, !disp_en_o}) mism++;
    end
    chk(mism == 0, "R5 status bits", mism, 0);
  endtask

  task automatic t_horizontal();
    frame_scan(); frame_scan();
    chk(m_hper_bad == 0, "R6 line period", m_hper_bad, 0);
    chk(m_hsw_bad == 0, "R6 hsync width", m_hsw_bad, 0);
    chk(m_dew_bad == 0, "R6 display width", m_dew_bad, 0);
    chk(m_hpos_bad == 0, "R6 hsync position", m_hpos_bad, 0);
  endtask

  task automatic t_vertical();
    frame_scan();
    chk(m_lines == 26, "R7 lines per frame", m_lines, 26);
    chk(m_de_lines == 15, "R7 displayed lines", m_de_lines, 15);
    chk(m_vs == 16, "R8 vsync lines", m_vs, 16);
  endtask

  task automatic t_refresh_cursor();
    frame_scan();
    chk(m_ma_bad == 0, "R9 refresh address with wrap", m_ma_bad, 0);
    chk(m_cur_bad == 0, "R10 cursor placement", m_cur_bad, 0);
    chk(m_cur == 2, "R10 cursor two lines", m_cur, 2);
    cfg_cs = 2; wr_reg(10, 2);
    frame_scan();
    chk(m_cur == 1, "R10 cursor window edge", m_cur, 1);
    cfg_ce = 1; wr_reg(11, 1);
    frame_scan();
    chk(m_cur == 0, "R10 empty cursor window", m_cur, 0);
    chk(m_cur_bad == 0, "R10 no stray cursor", m_cur_bad, 0);
    cfg_cs = 1; cfg_ce = 2; wr_reg(10, 1); wr_reg(11, 2);
  endtask

  task automatic t_video_off();
    bit r;
    io_write(4'h8, 8'h01, r);
    frame_scan();
    chk(m_de_lines == 0, "R4 video off display", m_de_lines, 0);
    chk(m_cur == 0, "R4 video off cursor", m_cur, 0);
  endtask

  task automatic t_blink();
    bit r; int shown = 0, bl = 0;
    io_write(4'h8, 8'h29, r);
    chk_cur = 0;
    frame_scan();
    for (int f = 0; f < 16; f++) begin
      frame_scan();
      if (m_cur > 0) shown++;
      if (blink_o) bl++;
    end
    chk(shown == 8, "R11 cursor frames of 16", shown, 8);
    chk(bl == 8, "R11 blink_o frames of 16", bl, 8);
    io_write(4'h8, 8'h09, r);
    @(negedge clk);
    chk(blink_o == 1'b0, "R11 blink_o off when disabled", blink_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_and_stall();
    t_program();
    t_ctrl_status();
    t_horizontal();
    t_vertical();
    t_refresh_cursor();
    t_video_off();
    t_blink();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule